// File: doc/BRIEF.md
# Dual-Issue In-Order Retire Buffer

This block tracks macro-ops from dispatch to commit in a circular buffer. It is parameterised by capacity, which defaults to 64 entries. Each dispatch beat allocates up to two entries and stores, for each one, how many micro-op completion reports it still needs. Two completion ports report finished micro-ops by entry index. Each report can also flag an exception. The buffer commits finished entries strictly oldest-first, at most two per cycle.

Two entries dispatched in the same beat can be linked as the halves of one wide operation. A linked pair commits as one unit: both halves in the same cycle, never one half alone. The block also decides on exceptions at commit time. When the oldest unit has finished and carries an exception, nothing commits in that cycle. The block pulses a flush naming the oldest index and empties the buffer.

Dispatch is a valid/ready stream. A beat is accepted on a cycle where `disp_valid[0]` and `disp_ready` are both high. `disp_ready` looks at how many lanes are valid: it drops when fewer free entries remain than the lanes requested, and it stays low during a flush cycle. While `disp_ready` is low, the source holds its beat unchanged. Completion reports and commit pulses carry no back-pressure.

Top module: `retire_buffer`

## Requirements
- R1: An accepted beat allocates `disp_valid[0]` at index `disp_idx0`, the current tail. If `disp_valid[1]` is also set, it allocates the next index `disp_idx1` (tail+1 modulo depth). `disp_valid[1]` is only set together with `disp_valid[0]`.
- R2: The buffer holds at most DEPTH entries in flight, with indices wrapping modulo DEPTH.
- R3: An entry becomes finished once it has received as many completion reports as its dispatched micro-op count, which is 1 or more. Two reports for the same index in one cycle count as two.
- R4: A beat with `disp_pair` set and both lanes valid links its two entries. Neither half commits until both are finished, and then both commit in the same cycle.
- R5: Commit is in program order, at most two entries per cycle. `cmt_valid[0]` marks the oldest entry at `cmt_idx0`. `cmt_valid[1]` marks the next one at `cmt_idx1`, and is only set with `cmt_valid[0]`. A finished entry waits while any older entry is unfinished.
- R6: `disp_ready` is low when the free entry count is less than the number of valid lanes, or during a flush. Otherwise it is high.
- R7: When the oldest unit is finished and carries an exception, no entry commits and `flush` is high for one cycle, with `flush_idx` set to the oldest index. In the next cycle the buffer is empty and allocation restarts at index 0.
- R8: An exception reported on either half of a linked pair flushes at the pair's first half, once both halves are finished.
- R9: A linked pair is never split across a commit boundary. If the oldest entry is unlinked and the next entry is the first half of a pair, only the oldest entry commits in that cycle.
- R10: After reset the buffer is empty: no commit, no flush, and `disp_ready` is high for a two-lane request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Dispatch lane valids (bit 0 is the older lane) |
| disp_ready | output | 1 | Dispatch beat accepted when high |
| disp_uops0 | input | UOPW | Micro-op count for lane 0 |
| disp_uops1 | input | UOPW | Micro-op count for lane 1 |
| disp_pair | input | 1 | Link the two lanes as one wide operation |
| disp_idx0 | output | IDXW | Index assigned to lane 0 |
| disp_idx1 | output | IDXW | Index assigned to lane 1 |
| cmp_valid | input | 2 | Completion report valids, one per port |
| cmp_idx0 | input | IDXW | Entry index for completion port 0 |
| cmp_idx1 | input | IDXW | Entry index for completion port 1 |
| cmp_exc | input | 2 | Exception flag, one per completion port |
| cmt_valid | output | 2 | Commit slot valids |
| cmt_idx0 | output | IDXW | Index committed in slot 0 |
| cmt_idx1 | output | IDXW | Index committed in slot 1 |
| flush | output | 1 | Exception flush pulse |
| flush_idx | output | IDXW | Index of the excepting oldest entry |

## Verification
The assertions rely on legal input: every completion report names an allocated entry that still owes reports, dispatched micro-op counts are nonzero, and lane 1 is never valid without lane 0. The stimulus keeps to these rules. The bench tracks the expected head and tail itself, reports only on entries it has allocated, and never sends more reports to an entry than its count. The bench uses small sizes, a depth of 8 and a two-bit count, and sweeps every pair of micro-op counts for both unlinked and linked beats, with completions deliberately out of order.

// File: rtl/retire_buffer_pkg.sv
package retire_buffer_pkg;
  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,
    RET_ONE   = 2'd1,
    RET_TWO   = 2'd2,
    RET_FLUSH = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/rb_ptrs.sv
module rb_ptrs #(
  parameter int DEPTH = 64,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [1:0]      push_n,
  input  logic [1:0]      pop_n,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [IDXW:0]   used
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      head <= '0;
      tail <= '0;
      used <= '0;
    end else begin
      head <= head + IDXW'(pop_n);
      tail <= tail + IDXW'(push_n);
      used <= used + (IDXW+1)'(push_n) - (IDXW+1)'(pop_n);
    end
  end

  // R2: occupancy never exceeds capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (IDXW+1)'(DEPTH));
  // R6: pushes never exceed free entries
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (IDXW+1)'(push_n) <= (IDXW+1)'(DEPTH) - used);
endmodule

// File: rtl/rb_table.sv
module rb_table #(
  parameter int DEPTH = 64,
  parameter int UOPW  = 3,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [1:0]      wr_en,
  input  logic [IDXW-1:0] wr_idx0,
  input  logic [IDXW-1:0] wr_idx1,
  input  logic [UOPW-1:0] wr_cnt0,
  input  logic [UOPW-1:0] wr_cnt1,
  input  logic            wr_link,
  input  logic [1:0]      cv,
  input  logic [IDXW-1:0] ci0,
  input  logic [IDXW-1:0] ci1,
  input  logic [1:0]      ce,
  input  logic [1:0]      pop_n,
  input  logic [IDXW-1:0] rd0,
  input  logic [IDXW-1:0] rd1,
  output logic [1:0]      r_done,
  output logic [1:0]      r_fault,
  output logic [1:0]      r_link
);
  logic            busy  [DEPTH];
  logic            link  [DEPTH];
  logic            fault [DEPTH];
  logic [UOPW-1:0] left  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [IDXW-1:0] ME = IDXW'(e);
    logic h0, h1, w0, w1, p;
    assign h0 = cv[0] && (ci0 == ME);
    assign h1 = cv[1] && (ci1 == ME);
    assign w0 = wr_en[0] && (wr_idx0 == ME);
    assign w1 = wr_en[1] && (wr_idx1 == ME);
    assign p  = ((pop_n != 2'd0) && (rd0 == ME)) || ((pop_n == 2'd2) && (rd1 == ME));
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        busy[e]  <= 1'b0;
        link[e]  <= 1'b0;
        fault[e] <= 1'b0;
        left[e]  <= '0;
      end else if (w0) begin
        busy[e]  <= 1'b1;
        link[e]  <= wr_link;
        fault[e] <= 1'b0;
        left[e]  <= wr_cnt0;
      end else if (w1) begin
        busy[e]  <= 1'b1;
        link[e]  <= 1'b0;
        fault[e] <= 1'b0;
        left[e]  <= wr_cnt1;
      end else begin
        if (p) busy[e] <= 1'b0;
        left[e] <= left[e] - UOPW'(h0) - UOPW'(h1);
        if ((h0 && ce[0]) || (h1 && ce[1])) fault[e] <= 1'b1;
      end
    end
  end

  assign r_done  = {busy[rd1] && (left[rd1] == '0), busy[rd0] && (left[rd0] == '0)};
  assign r_fault = {fault[rd1], fault[rd0]};
  assign r_link  = {link[rd1], link[rd0]};

  // R3: a report only targets an allocated entry that still owes reports
  a_r3_report_live0: assert property (@(posedge clk) disable iff (!rst_n)
    cv[0] |-> (busy[ci0] && left[ci0] != '0));
  a_r3_report_live1: assert property (@(posedge clk) disable iff (!rst_n)
    cv[1] |-> (busy[ci1] && left[ci1] != '0));
endmodule

// File: rtl/rb_pick.sv
module rb_pick
  import retire_buffer_pkg::*;
(
  input  logic [1:0] done,
  input  logic [1:0] fault,
  input  logic [1:0] link,
  output ret_kind_e  kind
);
  always_comb begin
    kind = RET_NONE;
    if (done[0]) begin
      if (link[0]) begin
        if (done[1]) kind = (fault[0] || fault[1]) ? RET_FLUSH : RET_TWO;
      end else if (fault[0]) begin
        kind = RET_FLUSH;
      end else if (done[1] && !fault[1] && !link[1]) begin
        kind = RET_TWO;
      end else begin
        kind = RET_ONE;
      end
    end
  end
endmodule

// File: rtl/retire_buffer.sv
module retire_buffer
  import retire_buffer_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int UOPW  = 3,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      disp_valid,
  output logic            disp_ready,
  input  logic [UOPW-1:0] disp_uops0,
  input  logic [UOPW-1:0] disp_uops1,
  input  logic            disp_pair,
  output logic [IDXW-1:0] disp_idx0,
  output logic [IDXW-1:0] disp_idx1,
  input  logic [1:0]      cmp_valid,
  input  logic [IDXW-1:0] cmp_idx0,
  input  logic [IDXW-1:0] cmp_idx1,
  input  logic [1:0]      cmp_exc,
  output logic [1:0]      cmt_valid,
  output logic [IDXW-1:0] cmt_idx0,
  output logic [IDXW-1:0] cmt_idx1,
  output logic            flush,
  output logic [IDXW-1:0] flush_idx
);
  logic [IDXW-1:0] head, tail;
  logic [IDXW:0]   used;
  logic [1:0]      req_n, push_n, pop_n, wr_en;
  logic [1:0]      hd_done, hd_fault, hd_link;
  logic            fire;
  ret_kind_e       kind;

  assign req_n      = {1'b0, disp_valid[0]} + {1'b0, disp_valid[1]};
  assign disp_ready = !flush && ((IDXW+1)'(req_n) <= (IDXW+1)'(DEPTH) - used);
  assign fire       = disp_valid[0] && disp_ready;
  assign push_n     = fire ? req_n : 2'd0;
  assign wr_en      = fire ? disp_valid : 2'b00;
  assign disp_idx0  = tail;
  assign disp_idx1  = tail + IDXW'(1);

  assign flush     = (kind == RET_FLUSH);
  assign flush_idx = head;
  assign cmt_valid = (kind == RET_TWO) ? 2'b11 : (kind == RET_ONE) ? 2'b01 : 2'b00;
  assign pop_n     = (kind == RET_TWO) ? 2'd2 : (kind == RET_ONE) ? 2'd1 : 2'd0;
  assign cmt_idx0  = head;
  assign cmt_idx1  = head + IDXW'(1);

  rb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push_n(push_n), .pop_n(pop_n),
    .head(head), .tail(tail), .used(used)
  );

  rb_table #(.DEPTH(DEPTH), .UOPW(UOPW)) u_table (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .wr_en(wr_en), .wr_idx0(disp_idx0), .wr_idx1(disp_idx1),
    .wr_cnt0(disp_uops0), .wr_cnt1(disp_uops1),
    .wr_link(disp_pair && disp_valid[1]),
    .cv(cmp_valid), .ci0(cmp_idx0), .ci1(cmp_idx1), .ce(cmp_exc),
    .pop_n(pop_n), .rd0(head), .rd1(cmt_idx1),
    .r_done(hd_done), .r_fault(hd_fault), .r_link(hd_link)
  );

  rb_pick u_pick (
    .done(hd_done), .fault(hd_fault), .link(hd_link), .kind(kind)
  );

  // R5: second slot only with the first
  a_r5_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid[1] |-> cmt_valid[0]);
  // R4: a linked first half commits only together with its partner
  a_r4_pair_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid[0] && hd_link[0]) |-> cmt_valid[1]);
  // R7: nothing commits or dispatches while flushing
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (cmt_valid == 2'b00 && !disp_ready));
  // R7: the cycle after a flush the buffer is empty at index 0
  a_r7_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (disp_idx0 == '0 && cmt_valid == 2'b00 && !flush));
  // R1: lane 1 never valid alone
  a_r1_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> disp_valid[0]);
endmodule

// File: tb/retire_buffer_tb_top.sv
`timescale 1ns/1ps
module retire_buffer_tb_top;
  localparam int DEPTH = 8;
  localparam int UOPW  = 2;
  localparam int IDXW  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      disp_valid = '0;
  logic            disp_ready;
  logic [UOPW-1:0] disp_uops0 = '0, disp_uops1 = '0;
  logic            disp_pair = 1'b0;
  logic [IDXW-1:0] disp_idx0, disp_idx1;
  logic [1:0]      cmp_valid = '0;
  logic [IDXW-1:0] cmp_idx0 = '0, cmp_idx1 = '0;
  logic [1:0]      cmp_exc = '0;
  logic [1:0]      cmt_valid;
  logic [IDXW-1:0] cmt_idx0, cmt_idx1;
  logic            flush;
  logic [IDXW-1:0] flush_idx;

  int n_run = 0, n_fail = 0;
  int tl = 0, hd = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  retire_buffer #(.DEPTH(DEPTH), .UOPW(UOPW)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    disp_valid = '0; disp_pair = 0; cmp_valid = '0; cmp_exc = '0;
  endtask

  task automatic dsp(int n, int u0, int u1, bit pr);
    disp_valid = (n == 2) ? 2'b11 : 2'b01;
    disp_uops0 = UOPW'(u0); disp_uops1 = UOPW'(u1); disp_pair = pr;
    #1;
    chk("R6 ready", int'(disp_ready), 1);
    chk("R1 idx0", int'(disp_idx0), tl);
    if (n == 2) chk("R1 idx1", int'(disp_idx1), (tl + 1) % DEPTH);
    tick();
    tl = (tl + n) % DEPTH;
  endtask

  task automatic cmp(int idx, bit exc);
    cmp_valid = 2'b01; cmp_idx0 = IDXW'(idx); cmp_exc = {1'b0, exc};
    tick();
  endtask

  task automatic see(string req, int n);
    #1;
    chk({req, " count"}, int'(cmt_valid[0]) + int'(cmt_valid[1]), n);
    chk({req, " order"}, int'(cmt_valid), (n == 2) ? 3 : n);
    if (n > 0) chk({req, " idx0"}, int'(cmt_idx0), hd);
    if (n == 2) chk({req, " idx1"}, int'(cmt_idx1), (hd + 1) % DEPTH);
    chk({req, " no flush"}, int'(flush), 0);
  endtask

  task automatic retire(int n);
    tick();
    hd = (hd + n) % DEPTH;
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    disp_valid = 2'b11; #1;
    chk("R10 ready", int'(disp_ready), 1);
    chk("R10 commit", int'(cmt_valid), 0);
    chk("R10 flush", int'(flush), 0);
    disp_valid = '0;
    tick();

    // R3 multi-report entry, dual report to one index
    dsp(1, 3, 0, 0);
    cmp_valid = 2'b11; cmp_idx0 = IDXW'(hd); cmp_idx1 = IDXW'(hd); tick();
    see("R3 partial", 0);
    cmp(hd, 0);
    see("R3 done", 1);
    retire(1);

    // R5 / R3 sweep: unlinked, younger completes first
    for (int a = 1; a <= 3; a++) begin
      for (int b = 1; b <= 3; b++) begin
        int ea, eb;
        ea = tl; eb = (tl + 1) % DEPTH;
        dsp(2, a, b, 0);
        for (int k = 0; k < b; k++) begin cmp(eb, 0); see("R5 younger waits", 0); end
        for (int k = 0; k < a; k++) begin
          cmp(ea, 0);
          see("R3 R5 dual", (k == a - 1) ? 2 : 0);
        end
        retire(2);
      end
    end

    // R4 sweep: linked pair, first half completes first
    for (int a = 1; a <= 3; a++) begin
      for (int b = 1; b <= 3; b++) begin
        int ea, eb;
        ea = tl; eb = (tl + 1) % DEPTH;
        dsp(2, a, b, 1);
        for (int k = 0; k < a; k++) begin cmp(ea, 0); see("R4 half waits", 0); end
        for (int k = 0; k < b; k++) begin
          cmp(eb, 0);
          see("R4 pair", (k == b - 1) ? 2 : 0);
        end
        retire(2);
      end
    end

    // R9 pair behind an unlinked entry
    begin
      int x;
      x = tl;
      dsp(1, 1, 0, 0);
      dsp(2, 1, 1, 1);
      cmp((x + 2) % DEPTH, 0);
      cmp((x + 1) % DEPTH, 0);
      see("R9 head pending", 0);
      cmp(x, 0);
      see("R9 single only", 1);
      retire(1);
      see("R9 pair next", 2);
      retire(2);
    end

    // R7 exception at oldest
    begin
      int a;
      a = tl;
      dsp(2, 1, 1, 0);
      cmp((a + 1) % DEPTH, 0);
      see("R7 pending", 0);
      cmp(a, 1);
      #1;
      chk("R7 flush", int'(flush), 1);
      chk("R7 flush idx", int'(flush_idx), a);
      chk("R7 no commit", int'(cmt_valid), 0);
      chk("R7 ready low", int'(disp_ready), 0);
      tick();
      tl = 0; hd = 0;
      see("R7 empty", 0);
      dsp(1, 1, 0, 0);
      see("R7 younger gone", 0);
      cmp(0, 0);
      see("R7 restart", 1);
      retire(1);
    end

    // R8 exception on second half of pair
    dsp(2, 1, 1, 1);
    cmp((hd + 1) % DEPTH, 1);
    see("R8 pending", 0);
    cmp(hd, 0);
    #1;
    chk("R8 flush", int'(flush), 1);
    chk("R8 flush idx", int'(flush_idx), hd);
    chk("R8 no commit", int'(cmt_valid), 0);
    tick();
    tl = 0; hd = 0;

    // R2 / R6 fill to capacity, then R7 flush from full
    dsp(2, 1, 1, 0); dsp(2, 1, 1, 0); dsp(2, 1, 1, 0);
    dsp(1, 1, 0, 0);
    disp_valid = 2'b11; #1;
    chk("R6 two into one free", int'(disp_ready), 0);
    disp_valid = 2'b01; #1;
    chk("R6 one into one free", int'(disp_ready), 1);
    chk("R2 idx wrap", int'(disp_idx0), 7);
    tick();
    tl = 0;
    disp_valid = 2'b01; #1;
    chk("R2 full stall", int'(disp_ready), 0);
    disp_valid = '0;
    cmp(hd, 1);
    #1;
    chk("R7 flush from full", int'(flush), 1);
    tick();
    tl = 0; hd = 0;
    dsp(2, 1, 1, 0);
    cmp2_done: begin
      cmp_valid = 2'b11; cmp_idx0 = 3'd1; cmp_idx1 = 3'd0; tick();
    end
    see("R5 dual after flush", 2);
    retire(2);

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule